// File: doc/BRIEF.md
# Synthesizer Lock Flag Detector

This block keeps a lock flag for a frequency synthesizer by watching the charge-pump activity pulse. It runs on the crystal clock and receives two inputs: the charge-pump pulse, which is an active-high level appearing at most once per reference period, and a one-cycle reference strobe that marks the last crystal cycle of each reference period. The strobe is made by dividing the crystal clock, by 64 in the intended setting, so one period is 16 µs at a 4 MHz crystal.

The width of each pulse is measured in crystal cycles. One wide pulse drops the flag on the next edge. Raising the flag again takes a run of clean reference periods: `RUN_LEN` of them in a row, eight by default. Setting the flag is therefore slow and clearing it is fast, which filters out chatter when the loop is close to lock. A reference period that has no pulse at all counts as clean.

A test-enable input routes the reference strobe to a debug output so that the period timing can be seen from outside.

Top module: `lock_flag_detector`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `lock_o` is 0 and the clean-period count is 0, so `RUN_LEN` clean periods are needed before the first lock.
- R2: The detector samples `cp_pulse_i` on every crystal clock edge. If the pulse is high on more than `NARROW_MAX_CYC` consecutive edges (two edges by default), `lock_o` goes to 0 right after the edge that makes it wide. This happens in the middle of a period and does not wait for the strobe.
- R3: A pulse that is high on no more than `NARROW_MAX_CYC` consecutive edges is narrow and leaves `lock_o` unchanged.
- R4: A period is closed by the edge on which `ref_stb_i` is 1. When the period just closed had no wide pulse and `RUN_LEN - 1` clean periods came right before it, `lock_o` rises after that edge. For example, after a wide pulse the flag rises on the strobe that ends the eighth clean period following the period that held the wide pulse.
- R5: A wide pulse resets the clean-period count to 0. If a wide pulse falls inside a partial run, the full `RUN_LEN` clean periods must follow before `lock_o` rises.
- R6: A reference period with no pulse counts as clean, the same as a period with a narrow pulse.
- R7: Once `lock_o` is 1, it stays 1 through any number of periods that contain only narrow pulses or no pulse.
- R8: `ref_dbg_o` equals `ref_stb_i` while `test_en_i` is 1 and is 0 while `test_en_i` is 0.
- R9: A pulse held high across one or more strobes marks every period it spans as wide. `lock_o` stays 0 during those periods, and the count of clean periods starts only after the pulse ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Crystal oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cp_pulse_i | input | 1 | Charge-pump activity pulse, active high |
| ref_stb_i | input | 1 | One-cycle strobe marking the end of a reference period |
| test_en_i | input | 1 | Sends the reference strobe to the debug output |
| lock_o | output | 1 | Lock flag |
| ref_dbg_o | output | 1 | Debug copy of the reference strobe |

## Verification
The hardest case to reach is a wide pulse that breaks a partial run of clean periods, combined with a pulse that is still high when the strobe arrives. Both cases depend on where the pulse edges fall relative to the period boundary. The bench builds every reference period from a task that places the pulse at a chosen offset with a chosen width. It then chains short runs, a wide pulse and further runs, and checks `lock_o` right after the seventh and eighth strobes. A pulse held high through whole periods, followed by an explicit release before the next period begins, covers the case where a pulse spans a strobe.

// File: rtl/lock_det_pkg.sv
package lock_det_pkg;
  localparam int unsigned LD_NARROW_MAX_DEF = 1;  // high samples still counted as narrow
  localparam int unsigned LD_RUN_LEN_DEF    = 8;  // clean periods needed to set lock

  function automatic int unsigned ld_cnt_w(int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/pulse_width_meter.sv
module pulse_width_meter
  import lock_det_pkg::*;
#(
  parameter int unsigned NARROW_MAX_CYC = LD_NARROW_MAX_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  output logic wide_o
);
  localparam int unsigned W = ld_cnt_w(NARROW_MAX_CYC);
  localparam logic [W-1:0] LIM = W'(NARROW_MAX_CYC);

  logic [W-1:0] cnt_q;

  // wide once the pulse is sampled high again after reaching the limit
  assign wide_o = pulse_i && (cnt_q == LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!pulse_i)    cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIM);
  assert_cnt_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_i |=> (cnt_q == '0));
endmodule

// File: rtl/narrow_run_counter.sv
module narrow_run_counter
  import lock_det_pkg::*;
#(
  parameter int unsigned RUN_LEN = LD_RUN_LEN_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_stb_i,
  input  logic wide_i,
  output logic set_o,
  output logic run_full_o
);
  localparam int unsigned RW = ld_cnt_w(RUN_LEN);
  localparam logic [RW-1:0] RUN_TOP = RW'(RUN_LEN);
  localparam logic [RW-1:0] RUN_PRE = RW'(RUN_LEN - 1);

  logic [RW-1:0] run_q;
  logic          seen_q;  // wide pulse seen in the current period

  assign set_o      = ref_stb_i && !wide_i && !seen_q && (run_q == RUN_PRE);
  assign run_full_o = (run_q == RUN_TOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      seen_q <= 1'b0;
    end else if (ref_stb_i) begin
      seen_q <= 1'b0;
      if (wide_i || seen_q)   run_q <= '0;
      else if (run_q != RUN_TOP) run_q <= run_q + 1'b1;
    end else if (wide_i) begin
      seen_q <= 1'b1;
      run_q  <= '0;
    end
  end

  assert_run_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RUN_TOP);
  assert_wide_zeroes_run_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wide_i |=> (run_q == '0));
  assert_run_moves_on_stb_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ref_stb_i && !wide_i) |=> $stable(run_q));
endmodule

// File: rtl/lock_flag_detector.sv
module lock_flag_detector
  import lock_det_pkg::*;
#(
  parameter int unsigned NARROW_MAX_CYC = LD_NARROW_MAX_DEF,
  parameter int unsigned RUN_LEN        = LD_RUN_LEN_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cp_pulse_i,
  input  logic ref_stb_i,
  input  logic test_en_i,
  output logic lock_o,
  output logic ref_dbg_o
);
  logic wide;
  logic set_lock;
  logic run_full;
  logic lock_q;

  pulse_width_meter #(.NARROW_MAX_CYC(NARROW_MAX_CYC)) i_meter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pulse_i(cp_pulse_i),
    .wide_o (wide)
  );

  narrow_run_counter #(.RUN_LEN(RUN_LEN)) i_run (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ref_stb_i (ref_stb_i),
    .wide_i    (wide),
    .set_o     (set_lock),
    .run_full_o(run_full)
  );

  // clear wins over set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lock_q <= 1'b0;
    else if (wide)     lock_q <= 1'b0;
    else if (set_lock) lock_q <= 1'b1;
  end

  assign lock_o    = lock_q;
  assign ref_dbg_o = test_en_i & ref_stb_i;

  assert_wide_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wide |=> !lock_q);
  assert_lock_run_agree_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q == run_full);
  assert_rise_on_stb_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_q) |-> $past(ref_stb_i));
  assert_hold_without_wide_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !wide) |=> lock_q);
endmodule

// File: tb/test_lock_flag_detector.sv
module test_lock_flag_detector;
  localparam int CLK_PERIOD = 10;
  localparam int REF_DIV    = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cp = 1'b0;
  logic stb = 1'b0;
  logic ten = 1'b0;
  logic lock;
  logic dbg;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lock_flag_detector i_lock_flag_detector (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .cp_pulse_i(cp),
    .ref_stb_i (stb),
    .test_en_i (ten),
    .lock_o    (lock),
    .ref_dbg_o (dbg)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // one reference period: pulse high for pw cycles from offset 0, strobe on last cycle
  task automatic period(input int pw);
    for (int c = 0; c < REF_DIV; c++) begin
      @(negedge clk);
      cp  = (c < pw);
      stb = (c == REF_DIV - 1);
    end
  endtask

  // let the last strobe edge land, then release inputs
  task automatic settle();
    @(negedge clk);
    cp  = 1'b0;
    stb = 1'b0;
  endtask

  task automatic clean_periods(input int n, input int pw);
    for (int i = 0; i < n; i++) begin
      period(pw);
      settle();
    end
  endtask

  task automatic t_reset();
    check("R1 lock during reset", lock, 1'b0);
    check("R8 dbg during reset", dbg, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 lock after reset", lock, 1'b0);
  endtask

  task automatic t_acquire_empty();
    clean_periods(7, 0);
    check("R6 no lock after 7 empty periods", lock, 1'b0);
    clean_periods(1, 0);
    check("R6 lock after 8 empty periods", lock, 1'b1);
  endtask

  task automatic t_hold_narrow();
    clean_periods(3, 1);
    check("R3 narrow pulses keep lock", lock, 1'b1);
    clean_periods(2, 0);
    check("R7 empty periods keep lock", lock, 1'b1);
  endtask

  task automatic t_wide_timing();
    @(negedge clk);
    cp = 1'b1;
    @(negedge clk);
    check("R3 one high sample keeps lock", lock, 1'b1);
    @(negedge clk);
    check("R2 lock clear after second high sample", lock, 1'b0);
    cp = 1'b0;
    for (int c = 3; c < REF_DIV; c++) begin
      @(negedge clk);
      stb = (c == REF_DIV - 1);
    end
    settle();
    check("R2 lock low after wide period", lock, 1'b0);
    clean_periods(7, 1);
    check("R4 no lock after 7 clean periods", lock, 1'b0);
    clean_periods(1, 1);
    check("R4 lock on 8th clean strobe", lock, 1'b1);
  endtask

  task automatic t_run_restart();
    clean_periods(1, 3);
    check("R2 wide pulse clears lock", lock, 1'b0);
    clean_periods(5, 1);
    clean_periods(1, 2);
    check("R5 wide in partial run", lock, 1'b0);
    clean_periods(7, 0);
    check("R5 no lock after 7 after restart", lock, 1'b0);
    clean_periods(1, 1);
    check("R5 lock after full run", lock, 1'b1);
  endtask

  task automatic t_stuck_high();
    period(REF_DIV);
    period(REF_DIV);
    check("R9 lock low while pulse spans strobe", lock, 1'b0);
    period(REF_DIV);
    settle();
    check("R9 lock low after held pulse", lock, 1'b0);
    clean_periods(7, 0);
    check("R9 no lock after 7 clean periods", lock, 1'b0);
    clean_periods(1, 0);
    check("R9 lock after 8 clean periods", lock, 1'b1);
  endtask

  task automatic t_debug();
    @(negedge clk);
    ten = 1'b1;
    stb = 1'b1;
    #1;
    check("R8 dbg follows strobe", dbg, 1'b1);
    @(negedge clk);
    stb = 1'b0;
    #1;
    check("R8 dbg low without strobe", dbg, 1'b0);
    @(negedge clk);
    ten = 1'b0;
    stb = 1'b1;
    #1;
    check("R8 dbg masked when test off", dbg, 1'b0);
    @(negedge clk);
    stb = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_acquire_empty();
    t_hold_narrow();
    t_wide_timing();
    t_run_restart();
    t_stuck_high();
    t_debug();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule